// File: doc/BRIEF.md
# Configurable Audio Serial Receiver

This block is the slave side of a serial audio link. It receives a bit clock, a word clock and one serial data line from an external master and turns the stream into parallel sample pairs. All three lines are oversampled in the system clock domain. The bit clock is never used as a clock inside the block, so any bit rate well below half the system clock is accepted.

One static configuration picks the framing: left-justified, right-justified, I2S, DSP or TDM (the last also serves telephony PCM framing). It also sets the word length, a start-of-data delay counted in bit clocks, which bit-clock edge samples the line, and which slot pair is taken in TDM. Each completed left/right pair appears on two 32-bit outputs with a one-cycle strobe. A word-clock transition that comes too early raises a one-cycle error pulse. The configuration is expected to change only while reset is held.

Top module: `audio_serial_rx`

## Requirements
- R1: With `cfg_bclk_inv_i`=0 the line is sampled on rising bit-clock edges; with 1 it is sampled on falling edges. The choice works the same in every framing mode.
- R2: Bits arrive most significant first. `cfg_wl_i` selects the word length: 0=16, 1=20, 2=24, 3=32 bits. Bits outside the word do not affect the output.
- R3: Left-justified (`cfg_mode_i`=0): a half-frame begins on the bit clock where the word clock is first seen changed. Data begins on that same bit. The left word is the one taken while the word clock is high.
- R4: I2S (`cfg_mode_i`=2): data begins one bit clock after the bit where the word-clock change is seen. The left word is the one taken while the word clock is low.
- R5: Right-justified (`cfg_mode_i`=1): the last bit before each word-clock change is the word's least significant bit, and the word is the final N bits of the half-frame. The offset setting has no effect. The pair is presented after the change that ends the right half (word clock high = left).
- R6: DSP (`cfg_mode_i`=3): a frame starts on the bit where a rising word clock is seen, whether the word clock is a one-bit pulse or a square wave. Slot 0 (left) begins one bit later, and slot 1 (right) follows directly.
- R7: TDM (`cfg_mode_i`=4): slot 0 begins on the bit where the rising word clock is seen. Slots of N bits follow back to back, and `cfg_slot_sel_i`=s selects slot 2s as left and slot 2s+1 as right.
- R8: `cfg_left_align_i`=1 places the word in the top N bits with zeros below. 0 sign-extends it from bit N-1.
- R9: `valid_o` pulses for exactly one clock per pair, with `left_o` and `right_o` updated together. No pair is presented unless its left word was taken in the same frame.
- R10: `err_o` pulses when a frame-start edge arrives before the current word (I2S, LJ) or both selected slots (DSP, TDM) are complete, or when a right-justified half-frame is shorter than N bits. No pair is presented from that frame.
- R11: During reset, `valid_o` and `err_o` are low and both sample outputs are zero. Reset is synchronous and active high.
- R12: `cfg_offset_i` delays the start of data by that many bit clocks in LJ, I2S, DSP and TDM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| wclk_i | input | 1 | Word clock / frame sync (asynchronous) |
| sdata_i | input | 1 | Serial data |
| cfg_mode_i | input | 3 | 0 LJ, 1 RJ, 2 I2S, 3 DSP, 4 TDM |
| cfg_wl_i | input | 2 | Word length code |
| cfg_offset_i | input | OFS_W | Data start delay in bit clocks |
| cfg_bclk_inv_i | input | 1 | Sample on falling bit-clock edge |
| cfg_slot_sel_i | input | SEL_W | TDM slot pair select |
| cfg_left_align_i | input | 1 | 1 left-align, 0 sign-extend |
| left_o | output | 32 | Left / even slot sample |
| right_o | output | 32 | Right / odd slot sample |
| valid_o | output | 1 | One-clock pair strobe |
| err_o | output | 1 | One-clock framing error pulse |

## Verification
Every mode is driven with frames whose bits outside the word window carry random noise. A window placed one bit wrong, or a word length mismatch, therefore shows up as wrong sample bits rather than hiding behind zero padding. Directed cases cover each mode at one word length: I2S with falling-edge sampling, DSP with both a pulse and a square word clock, TDM on a non-zero slot pair, and right-justified with an offset that must be ignored. Short frames in LJ, RJ and TDM check that the errors are counted exactly and that no pair is presented from them. A seeded random sweep then crosses mode, word length, offset, polarity, slot select, alignment and padding. That sweep separates the mode-specific start rules from the shared counting path.

// File: rtl/asrx_pkg.sv
package asrx_pkg;
  localparam int SMP_W = 32;

  typedef enum logic [2:0] {
    FM_LJ  = 3'd0,
    FM_RJ  = 3'd1,
    FM_I2S = 3'd2,
    FM_DSP = 3'd3,
    FM_TDM = 3'd4
  } fmode_e;

  function automatic logic [5:0] wl_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd20;
      2'd2:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  // Keep the low word bits and place them as requested.
  function automatic logic [SMP_W-1:0] shape(input logic [SMP_W-1:0] raw,
                                             input logic [1:0] code,
                                             input logic left);
    logic [5:0] sh;
    logic [SMP_W-1:0] up;
    logic signed [SMP_W-1:0] s;
    sh = 6'd32 - wl_bits(code);
    up = raw << sh;
    s  = $signed(up);
    return left ? up : SMP_W'(s >>> sh);
  endfunction
endpackage

// File: rtl/asrx_bit_sync.sv
module asrx_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  input  logic wclk,
  input  logic sdata,
  input  logic inv,
  output logic bit_stb,
  output logic wclk_s,
  output logic sdata_s
);
  localparam int NSIG = 3;
  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            b_prev;

  assign raw = {sdata, wclk, bclk};

  genvar g;
  generate
    for (g = 0; g < NSIG; g++) begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= {q[STAGES-2:0], raw[g]};
      end
      assign synced[g] = q[STAGES-1];
    end
  endgenerate

  logic active;
  assign active = inv ? (b_prev & ~synced[0]) : (~b_prev & synced[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      b_prev  <= 1'b0;
      bit_stb <= 1'b0;
      wclk_s  <= 1'b0;
      sdata_s <= 1'b0;
    end else begin
      b_prev  <= synced[0];
      bit_stb <= active;
      wclk_s  <= synced[1];
      sdata_s <= synced[2];
    end
  end

  // R1: one strobe per selected edge, never two in a row
  p_stb_gap_r1: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);
endmodule

// File: rtl/asrx_frame_ctl.sv
module asrx_frame_ctl
  import asrx_pkg::*;
#(
  parameter int POS_W = 10,
  parameter int OFS_W = 5,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             w,
  input  fmode_e           mode,
  input  logic [1:0]       wl_code,
  input  logic [OFS_W-1:0] offset,
  input  logic [SEL_W-1:0] slot_sel,
  output logic             sh_en,
  output logic             use_old,
  output logic             store_l,
  output logic             store_r,
  output logic             err_ev
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             wp;
  logic             locked;
  logic [POS_W-1:0] pos;

  logic             pulse_mode, rj_mode, edge_seen, live, in_left;
  logic [POS_W-1:0] p, wl_p, first, last_l, last_r, skip, need;
  logic [SEL_W-1:0] sel_eff;

  always_comb begin
    pulse_mode = (mode == FM_DSP) || (mode == FM_TDM);
    rj_mode    = (mode == FM_RJ);
    edge_seen  = pulse_mode ? (w & ~wp) : (w ^ wp);
    p          = edge_seen ? '0 : ((pos == POS_MAX) ? POS_MAX : pos + 1'b1);
    live       = locked | edge_seen;
    in_left    = (mode == FM_I2S) ? ~w : w;
    wl_p       = POS_W'(wl_bits(wl_code));
    sel_eff    = (mode == FM_TDM) ? slot_sel : '0;
    skip       = (POS_W'(sel_eff) * wl_p) << 1;
    first      = POS_W'(offset) +
                 (((mode == FM_I2S) || (mode == FM_DSP)) ? POS_W'(1) : POS_W'(0)) +
                 (pulse_mode ? skip : '0);
    last_l     = first + wl_p - 1'b1;
    last_r     = last_l + wl_p;
    need       = pulse_mode ? last_r : last_l;

    sh_en   = 1'b0;
    use_old = 1'b0;
    store_l = 1'b0;
    store_r = 1'b0;
    err_ev  = 1'b0;
    if (bit_stb) begin
      if (rj_mode) begin
        sh_en   = live;
        use_old = 1'b1;
        if (locked && edge_seen) begin
          if (pos < wl_p - 1'b1) err_ev = 1'b1;
          else if (in_left) store_r = 1'b1;  // right half just ended
          else              store_l = 1'b1;
        end
      end else begin
        if (locked && edge_seen && (pos < need)) err_ev = 1'b1;
        if (live && (p >= first) && (p <= (pulse_mode ? last_r : last_l)))
          sh_en = 1'b1;
        if (live && (p == last_l)) begin
          if (pulse_mode || in_left) store_l = 1'b1;
          else                       store_r = 1'b1;
        end
        if (live && pulse_mode && (p == last_r)) store_r = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= 1'b0;
      locked <= 1'b0;
      pos    <= '0;
    end else if (bit_stb) begin
      wp  <= w;
      pos <= p;
      if (edge_seen) locked <= 1'b1;
    end
  end

  // R10: an errored edge never also completes a word
  p_err_no_store_r10: assert property (@(posedge clk) disable iff (rst)
    err_ev |-> !(store_l || store_r));
  // R2: words are only advanced on a sampled bit
  p_store_on_bit_r2: assert property (@(posedge clk) disable iff (rst)
    (store_l || store_r || sh_en || err_ev) |-> bit_stb);
endmodule

// File: rtl/asrx_word_asm.sv
module asrx_word_asm
  import asrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             d,
  input  logic             sh_en,
  input  logic             use_old,
  input  logic             store_l,
  input  logic             store_r,
  input  logic             err_ev,
  input  logic [1:0]       wl_code,
  input  logic             left_align,
  output logic [SMP_W-1:0] left_o,
  output logic [SMP_W-1:0] right_o,
  output logic             valid_o
);
  logic [SMP_W-1:0] sh, lbuf, raw, val;
  logic             lgot;

  always_comb begin
    raw = use_old ? sh : {sh[SMP_W-2:0], d};
    val = shape(raw, wl_code, left_align);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      lbuf    <= '0;
      lgot    <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (sh_en) sh <= {sh[SMP_W-2:0], d};
      if (err_ev) lgot <= 1'b0;
      if (store_l) begin
        lbuf <= val;
        lgot <= 1'b1;
      end
      if (store_r && lgot) begin
        left_o  <= lbuf;
        right_o <= val;
        valid_o <= 1'b1;
        lgot    <= 1'b0;
      end
    end
  end

  // R9: the pair strobe is a single clock wide
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R8: a left-aligned 16-bit word leaves the low half clear
  p_left_align_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(left_align) && ($past(wl_code) == 2'd0)) |->
      ((left_o[15:0] == 16'd0) && (right_o[15:0] == 16'd0)));
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = 10,
  parameter int OFS_W       = 5,
  parameter int SEL_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_i,
  input  logic             wclk_i,
  input  logic             sdata_i,
  input  logic [2:0]       cfg_mode_i,
  input  logic [1:0]       cfg_wl_i,
  input  logic [OFS_W-1:0] cfg_offset_i,
  input  logic             cfg_bclk_inv_i,
  input  logic [SEL_W-1:0] cfg_slot_sel_i,
  input  logic             cfg_left_align_i,
  output logic [SMP_W-1:0] left_o,
  output logic [SMP_W-1:0] right_o,
  output logic             valid_o,
  output logic             err_o
);
  logic bit_stb, w_s, d_s;
  logic sh_en, use_old, store_l, store_r, err_ev;

  asrx_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bclk(bclk_i), .wclk(wclk_i), .sdata(sdata_i),
    .inv(cfg_bclk_inv_i), .bit_stb(bit_stb), .wclk_s(w_s), .sdata_s(d_s)
  );

  asrx_frame_ctl #(.POS_W(POS_W), .OFS_W(OFS_W), .SEL_W(SEL_W)) u_ctl (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .w(w_s),
    .mode(fmode_e'(cfg_mode_i)), .wl_code(cfg_wl_i), .offset(cfg_offset_i),
    .slot_sel(cfg_slot_sel_i), .sh_en(sh_en), .use_old(use_old),
    .store_l(store_l), .store_r(store_r), .err_ev(err_ev)
  );

  asrx_word_asm u_asm (
    .clk(clk), .rst(rst), .d(d_s), .sh_en(sh_en), .use_old(use_old),
    .store_l(store_l), .store_r(store_r), .err_ev(err_ev),
    .wl_code(cfg_wl_i), .left_align(cfg_left_align_i),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else     err_o <= err_ev;
  end

  // R11: reset leaves the strobes low on the next clock
  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> (!valid_o && !err_o));
  // R10: an error and a pair are never presented together
  p_err_excl_r10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !valid_o);
endmodule

// File: tb/audio_serial_rx_bench.sv
`timescale 1ns/1ps
module audio_serial_rx_bench;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [1:0] wlc = 2'd0;
  logic [4:0] ofs = 5'd0;
  logic inv = 1'b0;
  logic [1:0] sel = 2'd0;
  logic align = 1'b0;
  logic [31:0] left_o, right_o;
  logic valid_o, err_o;

  always #5 clk = ~clk;

  audio_serial_rx u_audio_serial_rx (
    .clk(clk), .rst(rst), .bclk_i(bclk), .wclk_i(wclk), .sdata_i(sdata),
    .cfg_mode_i(mode), .cfg_wl_i(wlc), .cfg_offset_i(ofs),
    .cfg_bclk_inv_i(inv), .cfg_slot_sel_i(sel), .cfg_left_align_i(align),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .err_o(err_o)
  );

  int checks = 0, fails = 0;
  int n_got = 0, n_err = 0, n_exp = 0;
  logic [31:0] got_l[32], got_r[32], exp_l[32], exp_r[32];
  logic [31:0] slots[8];
  bit done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (valid_o && n_got < 32) begin
        got_l[n_got] = left_o;
        got_r[n_got] = right_o;
        n_got++;
      end
      if (err_o) n_err++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int wlen(input logic [1:0] c);
    return (c == 2'd3) ? 32 : 16 + 4 * int'(c);
  endfunction

  function automatic logic [31:0] expect_fmt(input logic [31:0] v,
                                             input logic [1:0] c, input logic a);
    int n;
    logic [31:0] mask, m;
    n = wlen(c);
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    m = v & mask;
    if (a) return m << (32 - n);
    if (m[n-1]) return m | ~mask;
    return m;
  endfunction

  task automatic send_bit(input logic w, input logic d);
    wclk = w;
    sdata = d;
    bclk = inv;
    repeat (HALF) @(posedge clk);
    bclk = ~inv;
    repeat (HALF) @(posedge clk);
  endtask

  task automatic start_scn(input logic [2:0] m, input logic [1:0] c,
                           input logic [4:0] o, input logic iv,
                           input logic [1:0] s, input logic a);
    rst = 1'b1;
    mode = m; wlc = c; ofs = o; inv = iv; sel = s; align = a;
    bclk = iv; wclk = 1'b0; sdata = 1'b0;
    repeat (5) @(posedge clk);
    rst = 1'b0;
    n_got = 0; n_err = 0; n_exp = 0;
    repeat (3) @(posedge clk);
  endtask

  // Square word clock frame for LJ, RJ and I2S
  task automatic send_sq(input logic [31:0] l, input logic [31:0] r, input int hlen);
    int n, st;
    logic lvl, b;
    logic [31:0] v;
    n = wlen(wlc);
    st = int'(ofs) + ((mode == 3'd2) ? 1 : 0);
    for (int h = 0; h < 2; h++) begin
      lvl = (mode == 3'd2) ? logic'(h) : logic'(h == 0);
      v = (h == 0) ? l : r;
      for (int p = 0; p < hlen; p++) begin
        int k;
        b = logic'($urandom % 2);
        k = (mode == 3'd1) ? p - (hlen - n) : p - st;
        if (k >= 0 && k < n) b = v[n-1-k];
        send_bit(lvl, b);
      end
    end
  endtask

  // Frame-sync frame for DSP and TDM, slot contents from slots[]
  task automatic send_pl(input int flen, input bit sq);
    int n, st;
    logic b, w;
    n = wlen(wlc);
    st = int'(ofs) + ((mode == 3'd3) ? 1 : 0);
    for (int p = 0; p < flen; p++) begin
      int k;
      w = sq ? logic'(p < flen / 2) : logic'(p == 0);
      b = logic'($urandom % 2);
      k = p - st;
      if (k >= 0 && k < 8 * n) b = slots[k / n][n-1-(k % n)];
      send_bit(w, b);
    end
  endtask

  task automatic run_scn(input string req, input logic [2:0] m, input logic [1:0] c,
                         input logic [4:0] o, input logic iv, input logic [1:0] s,
                         input logic a, input int extra, input bit sq);
    int n, len, se, nmid;
    logic [31:0] l, r;
    nmid = 2;
    start_scn(m, c, o, iv, s, a);
    n = wlen(c);
    se = (m == 3'd4) ? int'(s) : 0;
    for (int f = 0; f < nmid + 2; f++) begin
      if (m == 3'd3 || m == 3'd4) begin
        for (int i = 0; i < 8; i++) slots[i] = $urandom;
        l = slots[2*se]; r = slots[2*se+1];
        len = int'(o) + 1 + 2 * (se + 1) * n + extra;
        send_pl(len, sq);
      end else begin
        l = $urandom; r = $urandom;
        len = n + int'(o) + 1 + extra;
        send_sq(l, r, len);
      end
      if (!(f == 0 && m == 3'd2) && !(f == nmid + 1 && m == 3'd1) && n_exp < 32) begin
        exp_l[n_exp] = expect_fmt(l, c, a);
        exp_r[n_exp] = expect_fmt(r, c, a);
        n_exp++;
      end
    end
    repeat (40) @(posedge clk);
    chk(n_got == n_exp, req, "pair count", 32'(n_got), 32'(n_exp));
    chk(n_err == 0, "R10", "spurious errors", 32'(n_err), 32'd0);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk(got_l[i] == exp_l[i], req, $sformatf("left %0d", i), got_l[i], exp_l[i]);
      chk(got_r[i] == exp_r[i], req, $sformatf("right %0d", i), got_r[i], exp_r[i]);
    end
  endtask

  task automatic run_err(input logic [2:0] m, input logic [1:0] c, input logic [1:0] s,
                         input int len, input int frames, input int exp_errs);
    start_scn(m, c, 5'd0, 1'b0, s, 1'b0);
    for (int f = 0; f < frames; f++) begin
      for (int i = 0; i < 8; i++) slots[i] = $urandom;
      if (m == 3'd4) send_pl(len, 1'b0);
      else send_sq($urandom, $urandom, len);
    end
    repeat (40) @(posedge clk);
    chk(n_err == exp_errs, "R10", "error pulses", 32'(n_err), 32'(exp_errs));
    chk(n_got == 0, "R10", "pairs from bad frames", 32'(n_got), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(valid_o == 1'b0, "R11", "valid in reset", 32'(valid_o), 32'd0);
    chk(err_o == 1'b0, "R11", "err in reset", 32'(err_o), 32'd0);
    chk(left_o == 32'd0, "R11", "left in reset", left_o, 32'd0);
    chk(right_o == 32'd0, "R11", "right in reset", right_o, 32'd0);

    run_scn("R3 R8 sign-extend LJ", 3'd0, 2'd0, 5'd0, 1'b0, 2'd0, 1'b0, 2, 1'b1);
    run_scn("R4 R1 I2S falling edge", 3'd2, 2'd2, 5'd0, 1'b1, 2'd0, 1'b1, 3, 1'b1);
    run_scn("R5 RJ offset ignored", 3'd1, 2'd1, 5'd3, 1'b0, 2'd0, 1'b0, 4, 1'b1);
    run_scn("R6 DSP pulse sync", 3'd3, 2'd3, 5'd0, 1'b0, 2'd0, 1'b0, 2, 1'b0);
    run_scn("R6 DSP square sync", 3'd3, 2'd0, 5'd0, 1'b1, 2'd0, 1'b1, 5, 1'b1);
    run_scn("R7 R12 TDM slot pair 2", 3'd4, 2'd0, 5'd2, 1'b0, 2'd2, 1'b0, 3, 1'b0);
    run_scn("R12 R2 LJ offset 7", 3'd0, 2'd0, 5'd7, 1'b0, 2'd0, 1'b1, 0, 1'b1);
    run_scn("R9 R2 LJ 32-bit exact fit", 3'd0, 2'd3, 5'd0, 1'b1, 2'd0, 1'b0, 0, 1'b1);

    // R10: short half-frames and early frame syncs
    run_err(3'd0, 2'd0, 2'd0, 10, 2, 3);
    run_err(3'd1, 2'd2, 2'd0, 20, 2, 3);
    run_err(3'd4, 2'd0, 2'd1, 40, 3, 2);

    for (int t = 0; t < 10; t++) begin
      logic [2:0] m;
      m = 3'($urandom % 5);
      run_scn("R1 R2 R12 random", m, 2'($urandom % 4), 5'($urandom % 8),
              1'($urandom % 2), 2'($urandom % 2), 1'($urandom % 2),
              int'($urandom % 4), 1'($urandom % 2));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule